// File: doc/BRIEF.md
# Product-Term Cluster Steering Fabric

This block sits between the AND array and the macrocells of a sixteen-slice logic group. It receives eighty product terms, five for each slice, plus three shared terms. From a static configuration bus it builds one sum-of-products bit for each macrocell. Each slice has a fast path that ORs only its own five terms. It also has a steered path that collects whole five-term clusters from its own slice and its near neighbours. A wide path ORs in the steered result of the slice four positions lower. Chaining that wide link across four slices reaches all eighty terms.

The fabric is purely combinational and has no storage. A configuration that sends any one cluster to more than one place is reported on an error output. The routing it describes is still carried out as written. The three shared terms reach their own outputs unchanged.

Top module: `pt_cluster_alloc`

## Requirements
- R1: The shared terms pass straight through: `sharedPtIn[0]` appears on `sharedClk`, `sharedPtIn[1]` on `sharedInit` and `sharedPtIn[2]` on `sharedOe`.
- R2: Each slice n has a six-bit field `cfgBus[6n+5:6n]`. When its bit 5 (fast) is set, `mcSum[n]` equals the OR of `ptIn[5n+4:5n]`, whatever the other configuration bits hold.
- R3: Bit 0 (keep) of slice n's field adds cluster n to slice n's steered sum.
- R4: Bit 1 of cluster n's field sends cluster n to slice n-1. Bit 2 sends it to slice n-2. Bit 3 sends it to slice n+1. A slice's steered sum is the OR of every cluster that reaches it.
- R5: Bit 4 (wide) of slice n makes slice n's chain sum equal to its steered sum ORed with the chain sum of slice n-4. A slice that is not in fast mode drives its chain sum on `mcSum[n]`. The chain sum is forwarded upward even when the slice itself is in fast mode.
- R6: A neighbour or wide source whose index falls outside 0..15 contributes 0. A cluster steered past either end is lost, and the wide bit of slices 0..3 has no effect.
- R7: A slice that is not in fast mode, receives no cluster and has no wide contribution drives 0. An all-zero configuration gives all-zero outputs and no error.
- R8: `routeErr` is 1 exactly when some slice has two or more of bits 0, 1, 2, 3 and 5 set in its field.
- R9: When slices 1, 5, 9 and 13 each collect the four clusters around them (n-1, n, n+1, n+2) and slices 5, 9 and 13 take the wide input, `mcSum[13]` is the OR of all eighty terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgBus | input | 96 | Static configuration, six bits per slice |
| ptIn | input | 80 | Product terms, five per slice cluster |
| sharedPtIn | input | 3 | Shared clock, initialization and enable terms |
| mcSum | output | 16 | Sum-of-products bit for each macrocell |
| sharedClk | output | 1 | Shared clock term |
| sharedInit | output | 1 | Shared initialization term |
| sharedOe | output | 1 | Shared output-enable term |
| routeErr | output | 1 | A cluster has more than one destination |

## Verification
The block holds no state. A mis-decoded strobe or a wrong neighbour index therefore shows on `mcSum` as soon as the inputs settle, but only while the affected cluster holds a true term and no other source of the same slice is already high. For that reason most stimulus uses sparse term patterns and single-term sweeps, and each slice is compared with a reference OR of exactly the clusters its configuration selects. A broken conflict decode shows on `routeErr` immediately for the offending field.

// File: rtl/pt_alloc_pkg.sv
package pt_alloc_pkg;

  // Per-slice configuration field layout (bit positions inside one field).
  localparam int CFG_TO_SELF  = 0;  // cluster joins own steered sum
  localparam int CFG_TO_PREV  = 1;  // cluster goes to slice n-1
  localparam int CFG_TO_PREV2 = 2;  // cluster goes to slice n-2
  localparam int CFG_TO_NEXT  = 3;  // cluster goes to slice n+1
  localparam int CFG_WIDE     = 4;  // accept chain sum of slice n-4
  localparam int CFG_FAST     = 5;  // fast path: own cluster only
  localparam int CFG_W        = 6;

  // Strobes from the decode to the datapath, one set per slice.
  typedef struct packed {
    logic bypass;    // drive own cluster OR to the macrocell
    logic takeWide;  // OR in the chain sum from the slice below by the wide step
    logic takeDn1;   // cluster n-1 arrives here
    logic takeUp2;   // cluster n+2 arrives here
    logic takeUp1;   // cluster n+1 arrives here
    logic takeSelf;  // own cluster joins the steered sum
  } sliceStrobe_t;

endpackage

// File: rtl/pt_cluster_or.sv
module pt_cluster_or #(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] terms,
  output logic             anyHit
);

  // Balanced reduction of one cluster's product terms.
  assign anyHit = |terms;

endmodule

// File: rtl/pt_alloc_ctrl.sv
module pt_alloc_ctrl
  import pt_alloc_pkg::*;
#(
  parameter int NUM_SLICES = 16,
  parameter int WIDE_STEP  = 4,
  localparam int CFG_TOTAL = NUM_SLICES * CFG_W
) (
  input  logic [CFG_TOTAL-1:0]              cfgBus,
  output sliceStrobe_t [NUM_SLICES-1:0]     strobes,
  output logic                              routeErr
);

  logic [NUM_SLICES-1:0] conflict;

  for (genvar n = 0; n < NUM_SLICES; n++) begin : g_slice
    localparam int BASE = n * CFG_W;

    logic fromNext;
    logic fromNext2;
    logic fromPrev;
    logic wideOk;
    logic [4:0] destBits;

    // Cluster n+1 routed downward by one.
    if (n + 1 < NUM_SLICES) begin : g_nx
      assign fromNext = cfgBus[(n + 1) * CFG_W + CFG_TO_PREV];
    end else begin : g_nx_none
      assign fromNext = 1'b0;
    end

    // Cluster n+2 routed downward by two.
    if (n + 2 < NUM_SLICES) begin : g_nx2
      assign fromNext2 = cfgBus[(n + 2) * CFG_W + CFG_TO_PREV2];
    end else begin : g_nx2_none
      assign fromNext2 = 1'b0;
    end

    // Cluster n-1 routed upward by one.
    if (n >= 1) begin : g_pv
      assign fromPrev = cfgBus[(n - 1) * CFG_W + CFG_TO_NEXT];
    end else begin : g_pv_none
      assign fromPrev = 1'b0;
    end

    // Wide input exists only when a slice lies a full step below.
    if (n >= WIDE_STEP) begin : g_wd
      assign wideOk = cfgBus[BASE + CFG_WIDE];
    end else begin : g_wd_none
      assign wideOk = 1'b0;
    end

    assign strobes[n] = '{
      bypass:   cfgBus[BASE + CFG_FAST],
      takeWide: wideOk,
      takeDn1:  fromPrev,
      takeUp2:  fromNext2,
      takeUp1:  fromNext,
      takeSelf: cfgBus[BASE + CFG_TO_SELF]
    };

    // Every destination a cluster can be claimed by.
    assign destBits = {cfgBus[BASE + CFG_FAST],
                       cfgBus[BASE + CFG_TO_NEXT],
                       cfgBus[BASE + CFG_TO_PREV2],
                       cfgBus[BASE + CFG_TO_PREV],
                       cfgBus[BASE + CFG_TO_SELF]};

    assign conflict[n] = ($countones(destBits) > 1);
  end

  // The wide bits of the lowest slices carry no route and are not decoded.
  if (WIDE_STEP > 0) begin : g_lowwide
    logic [WIDE_STEP-1:0] idleWide;
    for (genvar k = 0; k < WIDE_STEP; k++) begin : g_bit
      assign idleWide[k] = cfgBus[k * CFG_W + CFG_WIDE];
    end
    logic unusedWide;
    assign unusedWide = &{1'b0, idleWide};
  end

  assign routeErr = |conflict;

endmodule

// File: rtl/pt_wide_chain.sv
module pt_wide_chain #(
  parameter int NUM_SLICES = 16,
  parameter int WIDE_STEP  = 4
) (
  input  logic [NUM_SLICES-1:0] steered,
  input  logic [NUM_SLICES-1:0] takeWide,
  output logic [NUM_SLICES-1:0] chainSum
);

  // Ripple of OR stages, WIDE_STEP slices apart; lower slices settle first.
  always_comb begin
    chainSum = '0;
    for (int n = 0; n < NUM_SLICES; n++) begin
      if (n >= WIDE_STEP) begin
        chainSum[n] = steered[n] |
                      (takeWide[n] & chainSum[(n >= WIDE_STEP) ? n - WIDE_STEP : 0]);
      end else begin
        chainSum[n] = steered[n];
      end
    end
  end

endmodule

// File: rtl/pt_alloc_datapath.sv
module pt_alloc_datapath
  import pt_alloc_pkg::*;
#(
  parameter int NUM_SLICES  = 16,
  parameter int CLUSTER_PTS = 5,
  parameter int WIDE_STEP   = 4,
  localparam int NUM_PTS    = NUM_SLICES * CLUSTER_PTS,
  localparam int PAD_W      = NUM_SLICES + 3
) (
  input  logic [NUM_PTS-1:0]            ptIn,
  input  sliceStrobe_t [NUM_SLICES-1:0] strobes,
  output logic [NUM_SLICES-1:0]         mcSum
);

  logic [NUM_SLICES-1:0] clusterHit;
  logic [NUM_SLICES-1:0] steered;
  logic [NUM_SLICES-1:0] wideSel;
  logic [NUM_SLICES-1:0] chainSum;
  logic [PAD_W-1:0]      hitPad;

  for (genvar n = 0; n < NUM_SLICES; n++) begin : g_cluster
    pt_cluster_or #(.WIDTH(CLUSTER_PTS)) u_or (
      .terms  (ptIn[n * CLUSTER_PTS +: CLUSTER_PTS]),
      .anyHit (clusterHit[n])
    );
  end

  // Cluster i sits at hitPad[i+1]; the pad bits stand for absent slices.
  assign hitPad = {2'b00, clusterHit, 1'b0};

  for (genvar n = 0; n < NUM_SLICES; n++) begin : g_steer
    assign steered[n] = (strobes[n].takeSelf & hitPad[n + 1]) |
                        (strobes[n].takeUp1  & hitPad[n + 2]) |
                        (strobes[n].takeUp2  & hitPad[n + 3]) |
                        (strobes[n].takeDn1  & hitPad[n]);
    assign wideSel[n] = strobes[n].takeWide;
  end

  pt_wide_chain #(
    .NUM_SLICES (NUM_SLICES),
    .WIDE_STEP  (WIDE_STEP)
  ) u_chain (
    .steered  (steered),
    .takeWide (wideSel),
    .chainSum (chainSum)
  );

  for (genvar n = 0; n < NUM_SLICES; n++) begin : g_out
    assign mcSum[n] = strobes[n].bypass ? clusterHit[n] : chainSum[n];
  end

endmodule

// File: rtl/pt_cluster_alloc.sv
module pt_cluster_alloc
  import pt_alloc_pkg::*;
#(
  parameter int NUM_SLICES  = 16,
  parameter int CLUSTER_PTS = 5,
  parameter int WIDE_STEP   = 4,
  localparam int NUM_PTS    = NUM_SLICES * CLUSTER_PTS,
  localparam int CFG_TOTAL  = NUM_SLICES * CFG_W
) (
  input  logic [CFG_TOTAL-1:0]  cfgBus,
  input  logic [NUM_PTS-1:0]    ptIn,
  input  logic [2:0]            sharedPtIn,
  output logic [NUM_SLICES-1:0] mcSum,
  output logic                  sharedClk,
  output logic                  sharedInit,
  output logic                  sharedOe,
  output logic                  routeErr
);

  sliceStrobe_t [NUM_SLICES-1:0] strobes;

  pt_alloc_ctrl #(
    .NUM_SLICES (NUM_SLICES),
    .WIDE_STEP  (WIDE_STEP)
  ) u_ctrl (
    .cfgBus   (cfgBus),
    .strobes  (strobes),
    .routeErr (routeErr)
  );

  pt_alloc_datapath #(
    .NUM_SLICES  (NUM_SLICES),
    .CLUSTER_PTS (CLUSTER_PTS),
    .WIDE_STEP   (WIDE_STEP)
  ) u_dp (
    .ptIn    (ptIn),
    .strobes (strobes),
    .mcSum   (mcSum)
  );

  // Shared terms bypass the summing fabric entirely.
  assign sharedClk  = sharedPtIn[0];
  assign sharedInit = sharedPtIn[1];
  assign sharedOe   = sharedPtIn[2];

endmodule

// File: rtl/pt_cluster_alloc_chk.sv
module pt_cluster_alloc_chk
  import pt_alloc_pkg::*;
#(
  parameter int NUM_SLICES  = 16,
  parameter int CLUSTER_PTS = 5,
  parameter int WIDE_STEP   = 4,
  localparam int NUM_PTS    = NUM_SLICES * CLUSTER_PTS,
  localparam int CFG_TOTAL  = NUM_SLICES * CFG_W
) (
  input logic [CFG_TOTAL-1:0]  cfgBus,
  input logic [NUM_PTS-1:0]    ptIn,
  input logic [2:0]            sharedPtIn,
  input logic [NUM_SLICES-1:0] mcSum,
  input logic                  sharedClk,
  input logic                  sharedInit,
  input logic                  sharedOe,
  input logic                  routeErr
);

  logic fed;
  logic anyConflict;

  always_comb begin
    // R1
    no_shared_skew_chk: assert ({sharedOe, sharedInit, sharedClk} == sharedPtIn)
      else $error("shared terms altered");

    // R7
    if (cfgBus == '0) begin
      no_idle_leak_chk: assert (mcSum == '0 && !routeErr)
        else $error("idle configuration drives a sum");
    end

    anyConflict = 1'b0;
    fed = 1'b0;
    for (int n = 0; n < NUM_SLICES; n++) begin
      // R2
      if (cfgBus[n * CFG_W + CFG_FAST]) begin
        no_fast_slip_chk: assert (mcSum[n] == |ptIn[n * CLUSTER_PTS +: CLUSTER_PTS])
          else $error("fast path of slice %0d wrong", n);
      end

      fed = cfgBus[n * CFG_W + CFG_TO_SELF]
          | ((n + 1 < NUM_SLICES) ? cfgBus[((n + 1) % NUM_SLICES) * CFG_W + CFG_TO_PREV]  : 1'b0)
          | ((n + 2 < NUM_SLICES) ? cfgBus[((n + 2) % NUM_SLICES) * CFG_W + CFG_TO_PREV2] : 1'b0)
          | ((n >= 1) ? cfgBus[((n + NUM_SLICES - 1) % NUM_SLICES) * CFG_W + CFG_TO_NEXT] : 1'b0)
          | ((n >= WIDE_STEP) ? cfgBus[n * CFG_W + CFG_WIDE] : 1'b0);
      // R6
      if (!cfgBus[n * CFG_W + CFG_FAST] && mcSum[n]) begin
        no_phantom_sum_chk: assert (fed)
          else $error("slice %0d high with no source", n);
      end

      if ($countones({cfgBus[n * CFG_W + CFG_FAST], cfgBus[n * CFG_W + CFG_TO_NEXT],
                      cfgBus[n * CFG_W + CFG_TO_PREV2], cfgBus[n * CFG_W + CFG_TO_PREV],
                      cfgBus[n * CFG_W + CFG_TO_SELF]}) > 1) begin
        anyConflict = 1'b1;
      end
    end

    // R8
    no_conflict_miss_chk: assert (routeErr == anyConflict)
      else $error("route error flag disagrees with configuration");
  end

endmodule

bind pt_cluster_alloc pt_cluster_alloc_chk #(
  .NUM_SLICES  (NUM_SLICES),
  .CLUSTER_PTS (CLUSTER_PTS),
  .WIDE_STEP   (WIDE_STEP)
) u_chk (.*);

// File: tb/pt_cluster_alloc_tb.sv
module pt_cluster_alloc_tb;

  localparam int NS  = 16;
  localparam int CP  = 5;
  localparam int CW  = 6;
  localparam int NPT = NS * CP;
  localparam int STEP = 4;

  // Field bit positions as stated in R2..R5.
  localparam int B_KEEP = 0, B_DN1 = 1, B_DN2 = 2, B_UP1 = 3, B_WIDE = 4, B_FAST = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NS*CW-1:0] cfgBus = '0;
  logic [NPT-1:0]   ptIn = '0;
  logic [2:0]       sharedPtIn = '0;
  logic [NS-1:0]    mcSum;
  logic             sharedClk, sharedInit, sharedOe, routeErr;

  pt_cluster_alloc u_dut (
    .cfgBus     (cfgBus),
    .ptIn       (ptIn),
    .sharedPtIn (sharedPtIn),
    .mcSum      (mcSum),
    .sharedClk  (sharedClk),
    .sharedInit (sharedInit),
    .sharedOe   (sharedOe),
    .routeErr   (routeErr)
  );

  typedef struct {
    logic [NS-1:0] expSum;
    logic          expErr;
    logic [2:0]    expShared;
    string         req;
  } item_t;

  item_t sbq[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference: OR of exactly the clusters each configuration selects.
  function automatic logic [NS-1:0] refSum(input logic [NS*CW-1:0] c, input logic [NPT-1:0] p);
    logic [NS-1:0] own, steer, chain, res;
    own = '0; steer = '0; chain = '0; res = '0;
    for (int k = 0; k < NS; k++) own[k] = |p[k*CP +: CP];
    for (int k = 0; k < NS; k++) begin
      if (c[k*CW + B_KEEP]) steer[k] = steer[k] | own[k];
      if (c[k*CW + B_DN1] && k - 1 >= 0) steer[k-1] = steer[k-1] | own[k];
      if (c[k*CW + B_DN2] && k - 2 >= 0) steer[k-2] = steer[k-2] | own[k];
      if (c[k*CW + B_UP1] && k + 1 < NS) steer[k+1] = steer[k+1] | own[k];
    end
    for (int k = 0; k < NS; k++) begin
      chain[k] = steer[k];
      if (k >= STEP && c[k*CW + B_WIDE]) chain[k] = chain[k] | chain[k-STEP];
    end
    for (int k = 0; k < NS; k++) res[k] = c[k*CW + B_FAST] ? own[k] : chain[k];
    return res;
  endfunction

  function automatic logic refErr(input logic [NS*CW-1:0] c);
    logic e;
    e = 1'b0;
    for (int k = 0; k < NS; k++) begin
      int cnt;
      cnt = int'(c[k*CW+B_KEEP]) + int'(c[k*CW+B_DN1]) + int'(c[k*CW+B_DN2])
          + int'(c[k*CW+B_UP1]) + int'(c[k*CW+B_FAST]);
      if (cnt > 1) e = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [NPT-1:0] sparsePt();
    logic [NPT-1:0] p;
    for (int i = 0; i < NPT; i++) p[i] = ($urandom_range(0, 7) == 0);
    return p;
  endfunction

  function automatic logic [NPT-1:0] densePt();
    logic [NPT-1:0] p;
    for (int i = 0; i < NPT; i++) p[i] = $urandom_range(0, 1);
    return p;
  endfunction

  function automatic logic [NS*CW-1:0] allSlices(input int bitPos);
    logic [NS*CW-1:0] c;
    c = '0;
    for (int k = 0; k < NS; k++) c[k*CW + bitPos] = 1'b1;
    return c;
  endfunction

  function automatic logic [NS*CW-1:0] randCfg(input int conflictPct);
    logic [NS*CW-1:0] c;
    int pick;
    c = '0;
    for (int k = 0; k < NS; k++) begin
      pick = $urandom_range(0, 6);
      case (pick)
        0: c[k*CW+B_KEEP] = 1'b1;
        1: c[k*CW+B_DN1]  = 1'b1;
        2: c[k*CW+B_DN2]  = 1'b1;
        3: c[k*CW+B_UP1]  = 1'b1;
        4: c[k*CW+B_FAST] = 1'b1;
        default: ;
      endcase
      c[k*CW+B_WIDE] = $urandom_range(0, 1);
      if ($urandom_range(0, 99) < conflictPct) begin
        pick = $urandom_range(0, 4);
        c[k*CW + ((pick == 4) ? B_FAST : pick)] = 1'b1;
      end
    end
    return c;
  endfunction

  task automatic drive(input logic [NS*CW-1:0] c, input logic [NPT-1:0] p,
                       input logic [2:0] sh, input string req);
    item_t it;
    @(posedge clk);
    cfgBus = c;
    ptIn = p;
    sharedPtIn = sh;
    it.expSum = refSum(c, p);
    it.expErr = refErr(c);
    it.expShared = sh;
    it.req = req;
    sbq.push_back(it);
  endtask

  // Monitor: compares one pushed item per cycle, half a period after drive.
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() != 0) begin
        item_t it;
        it = sbq.pop_front();
        total++;
        if (mcSum !== it.expSum) begin
          bad++;
          $display("FAIL %s mcSum actual=%h expected=%h", it.req, mcSum, it.expSum);
        end
        total++;
        if (routeErr !== it.expErr) begin
          bad++;
          $display("FAIL R8 routeErr actual=%b expected=%b", routeErr, it.expErr);
        end
        total++;
        if ({sharedOe, sharedInit, sharedClk} !== it.expShared) begin
          bad++;
          $display("FAIL R1 shared actual=%b expected=%b",
                   {sharedOe, sharedInit, sharedClk}, it.expShared);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NS*CW-1:0] c;
    logic [NPT-1:0] p;

    // R7 reset state: zero configuration with busy terms.
    for (int i = 0; i < 4; i++) drive('0, densePt(), 3'b000, "R7");
    rst = 1'b0;

    // R1 shared terms under every code.
    for (int i = 0; i < 8; i++) drive('0, sparsePt(), 3'(i), "R1");

    // R2 fast path alone, then with wide bits that must not matter.
    for (int i = 0; i < 20; i++) drive(allSlices(B_FAST), sparsePt(), 3'($urandom_range(0,7)), "R2");
    for (int i = 0; i < 20; i++)
      drive(allSlices(B_FAST) | allSlices(B_WIDE), sparsePt(), 3'b000, "R2");

    // R3 own cluster into steered sum; single-term sweep pins the index.
    for (int i = 0; i < 20; i++) drive(allSlices(B_KEEP), sparsePt(), 3'b000, "R3");
    for (int i = 0; i < NPT; i++) drive(allSlices(B_KEEP), NPT'(1) << i, 3'b000, "R3");

    // R4 each steering direction across all slices.
    for (int i = 0; i < NPT; i++) drive(allSlices(B_DN1), NPT'(1) << i, 3'b000, "R4");
    for (int i = 0; i < NPT; i++) drive(allSlices(B_DN2), NPT'(1) << i, 3'b000, "R4");
    for (int i = 0; i < NPT; i++) drive(allSlices(B_UP1), NPT'(1) << i, 3'b000, "R4");

    // R6 clusters steered off either end are lost.
    c = '0;
    c[0*CW + B_DN1] = 1'b1;
    c[1*CW + B_DN2] = 1'b1;
    c[15*CW + B_UP1] = 1'b1;
    p = '0;
    p[0 +: CP] = '1;
    p[CP +: CP] = '1;
    p[15*CP +: CP] = '1;
    drive(c, p, 3'b000, "R6");
    // R6 wide bit of slices 0..3 has nothing to take.
    c = allSlices(B_WIDE);
    for (int k = 0; k < 4; k++) c[k*CW + B_KEEP] = 1'b1;
    for (int i = 0; i < 10; i++) drive(c, sparsePt(), 3'b000, "R6");

    // R5 wide chaining, including a fast slice that still forwards.
    for (int i = 0; i < 40; i++) drive(allSlices(B_KEEP) | allSlices(B_WIDE), sparsePt(), 3'b000, "R5");
    c = allSlices(B_WIDE);
    c[4*CW + B_FAST] = 1'b1;
    c[5*CW + B_DN1] = 1'b1;
    for (int i = 0; i < NPT; i++) drive(c, NPT'(1) << i, 3'b000, "R5");

    // R9 eighty-term chain ending at slice 13.
    c = '0;
    for (int s = 1; s < NS; s += STEP) begin
      c[(s-1)*CW + B_UP1] = 1'b1;
      c[s*CW + B_KEEP]    = 1'b1;
      c[(s+1)*CW + B_DN1] = 1'b1;
      c[(s+2)*CW + B_DN2] = 1'b1;
      if (s >= STEP) c[s*CW + B_WIDE] = 1'b1;
    end
    drive(c, '0, 3'b000, "R9");
    for (int i = 0; i < NPT; i++) drive(c, NPT'(1) << i, 3'b000, "R9");

    // R8 directed conflicts on one cluster, then random mixes.
    for (int k = 0; k < NS; k++) begin
      c = '0;
      c[k*CW + B_KEEP] = 1'b1;
      c[k*CW + ((k % 2 == 0) ? B_FAST : B_DN2)] = 1'b1;
      drive(c, sparsePt(), 3'b000, "R8");
    end
    for (int i = 0; i < 300; i++) drive(randCfg(15), sparsePt(), 3'($urandom_range(0,7)), "R8");

    // R4 R5 broad random coverage, legal configurations.
    for (int i = 0; i < 1200; i++) drive(randCfg(0), sparsePt(), 3'($urandom_range(0,7)), "R5");

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule